// File: doc/BRIEF.md
# Serial Ethernet Frame Check Sequence Unit

This block computes the 32-bit cyclic redundancy check that closes an Ethernet frame, one bit per clock. Bits arrive least significant bit of each byte first. The 32-bit register is loaded with all ones at the start of every frame, and each incoming bit enters at the x^0 end of the polynomial. The register is kept in reflected form, so bit 0 holds the x^31 coefficient.

A frame opens with a one-cycle `sof` pulse, which also samples `tx_mode`. With `tx_mode` high the unit generates a check sequence. After the `eod` pulse it emits 32 check bits on a valid/ready output stream. These bits are the ones' complement of the register, with the x^31 coefficient first, which is the reverse of the payload bit order.

With `tx_mode` low the unit checks a received frame. The whole frame, check field included, passes through the register. One cycle after `eod`, `res_good` reports whether the fixed residue remains, and the result holds until the next `sof`.

The input is a valid/ready stream. `in_ready` is high only during the data phase; a beat is taken when `in_valid` and `in_ready` are both high and `sof` is low. The output stream waits on `fcs_ready`: while `fcs_valid` is high and `fcs_ready` is low, `fcs_bit` does not change. `sof`, `eod` and `tx_mode` are plain control pins, not stream signals.

Top module: `eth_fcs_unit`

## Requirements
- R1: After synchronous reset `rst`, even one asserted in the middle of a frame, `in_ready`, `fcs_valid` and `res_valid` are all low.
- R2: A `sof` pulse in any state loads the register with all ones, latches `tx_mode` (1 = generate, 0 = check) and raises `in_ready` on the next cycle.
- R3: Each accepted beat steps the register once with polynomial 0x04C11DB7 (reflected constant 0xEDB88320), the bit entering at the x^0 end. Byte 0 is sent first, LSB first. For the ASCII bytes "123456789" the emitted check bits, packed with the first emitted bit as bit 0, form 0xCBF43926.
- R4: In generate mode, an `eod` pulse during the data phase raises `fcs_valid` on the next cycle. Exactly 32 bits are then handed over: the complement of the register, x^31 coefficient first. `fcs_valid` is low after the 32nd handshake.
- R5: While `fcs_valid` is high and `fcs_ready` is low, `fcs_valid` stays high and `fcs_bit` stays stable.
- R6: `in_ready` is low outside the data phase. Beats presented there leave the check sequence unchanged.
- R7: In check mode, `res_valid` rises on the cycle after `eod`. `res_good` is 1 exactly when the register holds 0xC704DD7B, read with x^31 as the MSB (0xDEBB20E3 in reflected form).
- R8: Once raised, `res_valid` and `res_good` hold until the next `sof`.
- R9: A `sof` in the middle of a frame restarts cleanly. A beat offered in the same cycle as `sof` is discarded.
- R10: `sof` clears `res_valid` on the next cycle.
- R11: Inverting any single bit of a good frame, whether in the data or the check field, gives `res_good` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof | input | 1 | Start-of-frame pulse; presets the register |
| tx_mode | input | 1 | Sampled at `sof`: 1 generate, 0 check |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat ready (data phase) |
| in_bit | input | 1 | Serial data bit |
| eod | input | 1 | End-of-data pulse |
| fcs_valid | output | 1 | Check-sequence bit valid |
| fcs_ready | input | 1 | Downstream accepts check-sequence bit |
| fcs_bit | output | 1 | Serial check-sequence bit |
| res_valid | output | 1 | Check result valid |
| res_good | output | 1 | Received frame had the good residue |

## Verification
The main function is exercised with several frames:
- The nine-byte ASCII digit string. It has a widely known check value and anchors the bit ordering and polynomial independently of any model.
- A single zero byte and an all-ones word. These separate the ones preset from a zero preset.
- A long frame with input gaps and output back-pressure. It shows that stalls neither add nor drop register steps.

Every generated sequence is fed back with its frame in check mode, which must report good.

Every bit position of a 64-bit framed message is then flipped in turn, and each flip must read bad.

Directed cases cover:
- an abort in the middle of a frame;
- a beat that coincides with `sof`;
- a reset during output;
- the persistence and clearing of the result.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned FCS_W = 32;
  // Generator 0x04C11DB7 in reflected form (bit 0 = x^31 coefficient)
  localparam logic [FCS_W-1:0] FCS_POLY_REFL = 32'hEDB88320;
  // Good-frame remainder, reflected form (0xC704DD7B with x^31 as MSB)
  localparam logic [FCS_W-1:0] FCS_RESIDUE_REFL = 32'hDEBB20E3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_SEND = 2'd2
  } fcs_state_e;
endpackage

// File: rtl/fcs_lfsr.sv
module fcs_lfsr #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = 32'hEDB88320
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         preset,
  input  logic         step,
  input  logic         din,
  input  logic         drain,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_step
);
  // One division step: shift toward bit 0, fold the polynomial when
  // the outgoing coefficient differs from the incoming bit.
  always_comb begin
    crc_step = {1'b0, crc_q[W-1:1]} ^ ((crc_q[0] ^ din) ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || preset) begin
      crc_q <= '1;
    end else if (step) begin
      crc_q <= crc_step;
    end else if (drain) begin
      crc_q <= {1'b1, crc_q[W-1:1]};
    end
  end
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic sof,
  input  logic tx_mode,
  input  logic eod,
  input  logic in_valid,
  input  logic fcs_ready,
  output logic in_ready,
  output logic beat,
  output logic fcs_valid,
  output logic fcs_fire,
  output logic rx_close
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  fcs_state_e       state;
  logic             mode_tx;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    in_ready  = (state == ST_DATA);
    beat      = in_valid & in_ready & ~sof;
    fcs_valid = (state == ST_SEND);
    fcs_fire  = fcs_valid & fcs_ready & ~sof;
    rx_close  = eod & in_ready & ~sof & ~mode_tx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_tx <= 1'b0;
      cnt     <= '0;
    end else if (sof) begin
      state   <= ST_DATA;
      mode_tx <= tx_mode;
      cnt     <= '0;
    end else begin
      unique case (state)
        ST_DATA: begin
          if (eod) begin
            state <= mode_tx ? ST_SEND : ST_IDLE;
            cnt   <= '0;
          end
        end
        ST_SEND: begin
          if (fcs_ready) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcs_judge.sv
module fcs_judge #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RESIDUE = 32'hDEBB20E3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sof,
  input  logic         close,
  input  logic [W-1:0] crc_final,
  output logic         res_valid,
  output logic         res_good
);
  always_ff @(posedge clk) begin
    if (rst || sof) begin
      res_valid <= 1'b0;
      res_good  <= 1'b0;
    end else if (close) begin
      res_valid <= 1'b1;
      res_good  <= (crc_final == RESIDUE);
    end
  end
endmodule

// File: rtl/eth_fcs_unit.sv
module eth_fcs_unit
  import fcs_pkg::*;
#(
  parameter int unsigned FCS_W_P = FCS_W,
  parameter logic [FCS_W_P-1:0] POLY = FCS_POLY_REFL,
  parameter logic [FCS_W_P-1:0] RESIDUE = FCS_RESIDUE_REFL
) (
  input  logic clk,
  input  logic rst,
  input  logic sof,
  input  logic tx_mode,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic eod,
  output logic fcs_valid,
  input  logic fcs_ready,
  output logic fcs_bit,
  output logic res_valid,
  output logic res_good
);
  logic               beat;
  logic               fcs_fire;
  logic               rx_close;
  logic [FCS_W_P-1:0] crc_q;
  logic [FCS_W_P-1:0] crc_step;
  logic [FCS_W_P-1:0] crc_final;

  fcs_seq #(.W(FCS_W_P)) u_seq (
    .clk(clk), .rst(rst), .sof(sof), .tx_mode(tx_mode), .eod(eod),
    .in_valid(in_valid), .fcs_ready(fcs_ready), .in_ready(in_ready),
    .beat(beat), .fcs_valid(fcs_valid), .fcs_fire(fcs_fire),
    .rx_close(rx_close)
  );

  fcs_lfsr #(.W(FCS_W_P), .POLY(POLY)) u_lfsr (
    .clk(clk), .rst(rst), .preset(sof), .step(beat), .din(in_bit),
    .drain(fcs_fire), .crc_q(crc_q), .crc_step(crc_step)
  );

  // A closing beat may share the eod cycle; judge the value it produces.
  assign crc_final = beat ? crc_step : crc_q;
  assign fcs_bit   = ~crc_q[0];

  fcs_judge #(.W(FCS_W_P), .RESIDUE(RESIDUE)) u_judge (
    .clk(clk), .rst(rst), .sof(sof), .close(rx_close),
    .crc_final(crc_final), .res_valid(res_valid), .res_good(res_good)
  );
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         sof,
  input logic         in_ready,
  input logic         fcs_valid,
  input logic         fcs_ready,
  input logic         fcs_bit,
  input logic         res_valid,
  input logic         res_good,
  input logic [W-1:0] crc_q
);
  localparam int unsigned SC_W = $clog2(W) + 1;
  logic [SC_W-1:0] sent;

  always_ff @(posedge clk) begin
    if (rst || !fcs_valid) sent <= '0;
    else if (fcs_ready) sent <= sent + 1'b1;
  end

  // R2
  sof_preset_chk: assert property (@(posedge clk) disable iff (rst)
    sof |=> (crc_q == {W{1'b1}}) && in_ready);

  // R5
  fcs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fcs_valid && !fcs_ready && !sof |=> fcs_valid && $stable(fcs_bit));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && !sof |=> res_valid && $stable(res_good));

  // R10
  res_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sof |=> !res_valid);

  // R4
  fcs_len_chk: assert property (@(posedge clk) disable iff (rst)
    fcs_valid |-> sent < SC_W'(W));

  // R6
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    fcs_valid && !sof |=> !in_ready || $past(fcs_ready));
endmodule

bind eth_fcs_unit fcs_chk #(.W(FCS_W_P)) u_chk (
  .clk(clk), .rst(rst), .sof(sof), .in_ready(in_ready),
  .fcs_valid(fcs_valid), .fcs_ready(fcs_ready), .fcs_bit(fcs_bit),
  .res_valid(res_valid), .res_good(res_good), .crc_q(crc_q)
);

// File: tb/eth_fcs_unit_tb.sv
module eth_fcs_unit_tb;
  logic clk = 1'b0;
  logic rst, sof, tx_mode, in_valid, in_ready, in_bit, eod;
  logic fcs_valid, fcs_ready, fcs_bit, res_valid, res_good;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  eth_fcs_unit u_dut (
    .clk(clk), .rst(rst), .sof(sof), .tx_mode(tx_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .eod(eod),
    .fcs_valid(fcs_valid), .fcs_ready(fcs_ready), .fcs_bit(fcs_bit),
    .res_valid(res_valid), .res_good(res_good)
  );

  localparam int NV = 6;
  localparam logic [127:0] V_DATA [NV] = '{
    128'h393837363534333231,
    128'h00,
    128'hFFFFFFFF,
    128'h0123456789ABCDEF_FEDCBA9876543210,
    128'hA5A55A5A0F0F,
    128'h8001
  };
  localparam int V_LEN [NV] = '{9, 1, 4, 16, 6, 2};
  localparam bit V_GAP [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit V_BP  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  function automatic logic [31:0] model_fcs(logic [127:0] d, int nb);
    logic [31:0] c = 32'hFFFFFFFF;
    logic fb;
    for (int i = 0; i < nb * 8; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return ~c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    sof = 0; eod = 0; in_valid = 0; fcs_ready = 0;
  endtask

  task automatic start(input logic mode, input logic beat_on_sof);
    @(negedge clk);
    sof = 1; tx_mode = mode; eod = 0; in_valid = beat_on_sof; in_bit = 1;
    fcs_ready = 0;
  endtask

  task automatic push(input logic b, input bit gap);
    if (gap) begin
      @(negedge clk);
      sof = 0; eod = 0; in_valid = 0;
    end
    @(negedge clk);
    sof = 0; eod = 0; in_valid = 1; in_bit = b;
  endtask

  task automatic close_data();
    @(negedge clk);
    sof = 0; in_valid = 0; eod = 1;
  endtask

  task automatic run_tx(input logic [127:0] d, input int nb, input bit gap,
                        input bit bp, output logic [31:0] word);
    int nsent = 0;
    start(1'b1, 1'b0);
    for (int i = 0; i < nb * 8; i++) push(d[i], gap && (i % 3 == 0));
    close_data();
    word = '0;
    for (int k = 0; k < 300 && nsent < 32; k++) begin
      @(negedge clk);
      eod = 0; in_valid = 1; in_bit = k[0];
      fcs_ready = bp ? (k % 3 != 1) : 1'b1;
      if (k == 0) begin
        chk(fcs_valid == 1'b1, "R4 fcs_valid after eod", {31'd0, fcs_valid}, 1);
        chk(in_ready == 1'b0, "R6 in_ready low while sending", {31'd0, in_ready}, 0);
      end
      if (fcs_ready && fcs_valid) begin
        word[nsent] = fcs_bit;
        nsent++;
      end
    end
    idle();
    chk(fcs_valid == 1'b0 && nsent == 32, "R4 exactly 32 bits",
        nsent, 32);
  endtask

  task automatic run_rx(input logic [127:0] d, input int nb, input logic [31:0] f,
                        input int flip, input logic beat_on_sof,
                        output logic v, output logic g);
    logic b;
    start(1'b0, beat_on_sof);
    for (int i = 0; i < nb * 8 + 32; i++) begin
      b = (i < nb * 8) ? d[i] : f[i - nb * 8];
      if (i == flip) b = ~b;
      push(b, 1'b0);
    end
    close_data();
    @(negedge clk);
    eod = 0;
    v = res_valid; g = res_good;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w, exp;
    logic v, g;
    rst = 1; sof = 0; tx_mode = 0; in_valid = 0; in_bit = 0; eod = 0;
    fcs_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!in_ready && !fcs_valid && !res_valid, "R1 reset outputs",
        {29'd0, in_ready, fcs_valid, res_valid}, 0);

    for (int n = 0; n < NV; n++) begin
      exp = model_fcs(V_DATA[n], V_LEN[n]);
      run_tx(V_DATA[n], V_LEN[n], V_GAP[n], V_BP[n], w);
      chk(w == exp, "R3 R4 generated sequence", w, exp);
      if (n == 0) chk(w == 32'hCBF43926, "R3 check string", w, 32'hCBF43926);
      run_rx(V_DATA[n], V_LEN[n], w, -1, 1'b0, v, g);
      chk(v && g, "R7 good frame", {30'd0, v, g}, 3);
      run_rx(V_DATA[n], V_LEN[n], w, (n * 5) % (V_LEN[n] * 8 + 32), 1'b0, v, g);
      chk(v && !g, "R11 corrupted frame", {30'd0, v, g}, 2);
    end

    // R8 result persists
    exp = model_fcs(V_DATA[2], 4);
    run_rx(V_DATA[2], 4, exp, -1, 1'b0, v, g);
    repeat (5) idle();
    chk(res_valid && res_good, "R8 result held", {30'd0, res_valid, res_good}, 3);

    // R2 / R10
    start(1'b0, 1'b0);
    @(negedge clk);
    sof = 0;
    chk(!res_valid, "R10 sof clears result", {31'd0, res_valid}, 0);
    chk(in_ready, "R2 in_ready after sof", {31'd0, in_ready}, 1);

    // R9 abort mid-frame then restart; beat on sof discarded
    for (int i = 0; i < 20; i++) push(i[1], 1'b0);
    run_rx(V_DATA[2], 4, exp, -1, 1'b0, v, g);
    chk(v && g, "R9 restart after abort", {30'd0, v, g}, 3);
    run_rx(V_DATA[2], 4, exp, -1, 1'b1, v, g);
    chk(v && g, "R9 beat on sof dropped", {30'd0, v, g}, 3);

    // R11 every single-bit flip
    for (int p = 0; p < 64; p++) begin
      run_rx(V_DATA[2], 4, exp, p, 1'b0, v, g);
      chk(v && !g, "R11 flip position", p, 32'hFFFF);
    end

    // R1 reset during output
    start(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) push(1'b1, 1'b0);
    close_data();
    @(negedge clk);
    eod = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    chk(!in_ready && !fcs_valid && !res_valid, "R1 reset mid-frame",
        {29'd0, in_ready, fcs_valid, res_valid}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule